// File: doc/BRIEF.md
# Pipelined Bus Link Protocol Monitor

This block sits beside one pipelined master/slave bus link and watches it without driving anything back. Every clock it samples the cycle, strobe, stall, acknowledge and error lines together with the request fields. It counts the requests the slave accepts and the responses it returns, and derives how many transactions are still in flight. It raises sticky violation flags whenever the traffic breaks a protocol rule or one of the configured limits.

Several rules can be switched by parameter to suit the master being watched. Some masters keep the cycle open across a read-modify-write pair. Some let the strobe pause while answers are still pending. Some slaves must never answer in the clock that accepts a request. The stall limit and the response-wait limit are parameters, and a limit of zero switches its check off. A single any-violation output gives a cheap hook for a debug trigger or an interrupt.

Top module: `bus_link_monitor`

## Requirements
- R1: A request is accepted on a clock where `cyc`, `stb` are high and `stall` is low. `req_count` rises by one (modulo 2^DEPTH_BITS) after each such clock.
- R2: A response is any clock with `cyc` high and `ack` or `err` high. `rsp_count` rises by one after each such clock.
- R3: Both counts return to zero after reset and after any clock with `cyc` low. `inflight` equals `req_count - rsp_count` while `cyc` is high and is zero in the same clock that `cyc` is low.
- R4: Flag bit 0 sets when `inflight` equals all-ones during an active cycle. It becomes visible after the edge that follows the clock in which the count reached that value.
- R5: With MAX_REQ nonzero, flag bit 1 sets when a request is accepted while `req_count` is already at MAX_REQ or above.
- R6: With STALL_LIMIT nonzero, flag bit 2 sets on the (STALL_LIMIT+1)-th consecutive clock with `cyc`, `stb` and `stall` all high. A limit of zero disables this check.
- R7: With RSP_LIMIT nonzero, flag bit 3 sets on the (RSP_LIMIT+1)-th consecutive clock with `cyc` high, `inflight` nonzero and no response. A limit of zero disables this check.
- R8: With NEED_DELAY set, flag bit 4 sets when a response arrives in the clock of an acceptance while nothing else is in flight. With NEED_DELAY clear, that response is legal.
- R9: Flag bit 5 sets on a response with nothing in flight and no acceptance in that clock. Flag bit 6 sets when `ack` and `err` are high together during a cycle.
- R10: With ALLOW_HOLD_OPEN clear, flag bit 7 sets on a clock with `cyc` high, `stb` low, `inflight` zero and no response.
- R11: With ALLOW_GAPS clear, flag bit 8 sets when `stb` rises while `cyc` stayed high from the previous clock.
- R12: After a stalled strobe, flag bit 9 sets if the next clock still has `cyc` high but has `stb` low, or has changed `we`, `adr`, `dat_w` or `sel`.
- R13: Each flag sets after the edge that samples its condition and stays set until reset. `viol_any` is the OR of all flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cyc | input | 1 | Bus cycle active |
| stb | input | 1 | Request strobe |
| we | input | 1 | Write enable of the request |
| adr | input | AW | Request address |
| dat_w | input | DW | Write data |
| sel | input | DW/8 | Byte selects |
| ack | input | 1 | Slave acknowledge |
| stall | input | 1 | Slave stall |
| err | input | 1 | Slave error response |
| req_count | output | DEPTH_BITS | Accepted requests in this cycle |
| rsp_count | output | DEPTH_BITS | Returned responses in this cycle |
| inflight | output | DEPTH_BITS | Transactions awaiting a response |
| viol | output | 10 | Sticky violation flags, bit positions per R4-R12 |
| viol_any | output | 1 | OR of all violation flags |

## Verification
The bench builds two instances that watch the same wires. The strict instance has hold-open and gaps forbidden, a minimum response delay, a stall limit of 3, a response limit of 4 and a request cap of 6. It brings R5-R8, R10 and R11 within reach with short sequences. The permissive instance allows hold-open and gaps, permits same-clock answers and has both timers at zero. It shows that each disabled rule stays silent on the same stimulus, and it lets 15 requests pile up so that the depth flag can fire without the timers firing first.

// File: rtl/bus_mon_pkg.sv
package bus_mon_pkg;

    localparam int NUM_FLAGS    = 10;
    localparam int FLG_DEPTH    = 0;
    localparam int FLG_REQ_CAP  = 1;
    localparam int FLG_STALL_TO = 2;
    localparam int FLG_RSP_TO   = 3;
    localparam int FLG_EARLY    = 4;
    localparam int FLG_ORPHAN   = 5;
    localparam int FLG_DUAL     = 6;
    localparam int FLG_IDLE     = 7;
    localparam int FLG_GAP      = 8;
    localparam int FLG_HOLD     = 9;

    typedef logic [NUM_FLAGS-1:0] flag_vec_t;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/mon_counters.sv
module mon_counters #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cyc,
    input  logic          accept,
    input  logic          respond,
    output logic [CW-1:0] req_q,
    output logic [CW-1:0] rsp_q,
    output logic [CW-1:0] inflight
);
    typedef struct packed {
        logic [CW-1:0] req;
        logic [CW-1:0] rsp;
    } cnt_t;

    cnt_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!cyc) begin
            st_d.req = '0;
            st_d.rsp = '0;
        end else begin
            if (accept)  st_d.req = st_q.req + 1'b1;
            if (respond) st_d.rsp = st_q.rsp + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign req_q    = st_q.req;
    assign rsp_q    = st_q.rsp;
    assign inflight = cyc ? (st_q.req - st_q.rsp) : '0;

endmodule

// File: rtl/mon_timer.sv
module mon_timer #(
    parameter int LIMIT = 4,
    parameter int W     = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic active,
    output logic expired
);
    localparam logic [W-1:0] LIM = W'(LIMIT);
    localparam bit ENABLED = (LIMIT != 0);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        if (!active)           cnt_d = '0;
        else if (cnt_q != LIM) cnt_d = cnt_q + 1'b1;
        else                   cnt_d = cnt_q;
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    assign expired = ENABLED && active && (cnt_q == LIM);

endmodule

// File: rtl/mon_hold.sv
module mon_hold #(
    parameter int AW = 16,
    parameter int DW = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cyc,
    input  logic            stb,
    input  logic            stall,
    input  logic            we,
    input  logic [AW-1:0]   adr,
    input  logic [DW-1:0]   dat_w,
    input  logic [DW/8-1:0] sel,
    output logic            broke
);
    typedef struct packed {
        logic            pend;
        logic            we;
        logic [AW-1:0]   adr;
        logic [DW-1:0]   dat;
        logic [DW/8-1:0] sel;
    } hold_t;

    hold_t st_d, st_q;
    logic  stalled;
    logic  moved;

    always_comb begin
        stalled = cyc && stb && stall;
        st_d    = st_q;
        st_d.pend = stalled;
        if (stalled) begin
            st_d.we  = we;
            st_d.adr = adr;
            st_d.dat = dat_w;
            st_d.sel = sel;
        end
        moved = (we != st_q.we) || (adr != st_q.adr) ||
                (dat_w != st_q.dat) || (sel != st_q.sel);
        broke = st_q.pend && cyc && (!stb || moved);
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

endmodule

// File: rtl/bus_link_monitor.sv
module bus_link_monitor
    import bus_mon_pkg::*;
#(
    parameter int AW              = 16,
    parameter int DW              = 32,
    parameter int DEPTH_BITS      = 4,
    parameter int MAX_REQ         = 0,
    parameter int STALL_LIMIT     = 4,
    parameter int RSP_LIMIT       = 8,
    parameter bit ALLOW_HOLD_OPEN = 1'b1,
    parameter bit ALLOW_GAPS      = 1'b0,
    parameter bit NEED_DELAY      = 1'b0
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cyc,
    input  logic                  stb,
    input  logic                  we,
    input  logic [AW-1:0]         adr,
    input  logic [DW-1:0]         dat_w,
    input  logic [DW/8-1:0]       sel,
    input  logic                  ack,
    input  logic                  stall,
    input  logic                  err,
    output logic [DEPTH_BITS-1:0] req_count,
    output logic [DEPTH_BITS-1:0] rsp_count,
    output logic [DEPTH_BITS-1:0] inflight,
    output logic [NUM_FLAGS-1:0]  viol,
    output logic                  viol_any
);
    localparam int MAX_DLY = imax(STALL_LIMIT, RSP_LIMIT);
    localparam int DLY_W   = $clog2(MAX_DLY + 1) + 1;
    localparam logic [DEPTH_BITS-1:0] ALL_ONES = '1;
    localparam logic [DEPTH_BITS-1:0] REQ_CAP  = DEPTH_BITS'(MAX_REQ);
    localparam bit CAP_ON = (MAX_REQ != 0);

    typedef struct packed {
        flag_vec_t viol;
        logic      cyc_prev;
        logic      stb_prev;
    } mon_t;

    mon_t      st_d, st_q;
    flag_vec_t fresh;
    logic      accept, respond;
    logic      stall_active, wait_active;
    logic      stall_expired, wait_expired;
    logic      hold_broke;
    logic      none_inflight;

    assign accept       = cyc && stb && !stall;
    assign respond      = cyc && (ack || err);
    assign stall_active = cyc && stb && stall;
    assign wait_active  = cyc && (inflight != '0) && !(ack || err);

    mon_counters #(.CW(DEPTH_BITS)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .cyc      (cyc),
        .accept   (accept),
        .respond  (respond),
        .req_q    (req_count),
        .rsp_q    (rsp_count),
        .inflight (inflight)
    );

    mon_timer #(.LIMIT(STALL_LIMIT), .W(DLY_W)) u_stall_tmr (
        .clk     (clk),
        .rst     (rst),
        .active  (stall_active),
        .expired (stall_expired)
    );

    mon_timer #(.LIMIT(RSP_LIMIT), .W(DLY_W)) u_wait_tmr (
        .clk     (clk),
        .rst     (rst),
        .active  (wait_active),
        .expired (wait_expired)
    );

    mon_hold #(.AW(AW), .DW(DW)) u_hold (
        .clk   (clk),
        .rst   (rst),
        .cyc   (cyc),
        .stb   (stb),
        .stall (stall),
        .we    (we),
        .adr   (adr),
        .dat_w (dat_w),
        .sel   (sel),
        .broke (hold_broke)
    );

    always_comb begin
        none_inflight = (inflight == '0);
        fresh = '0;
        fresh[FLG_DEPTH]    = cyc && (inflight == ALL_ONES);
        fresh[FLG_REQ_CAP]  = CAP_ON && accept && (req_count >= REQ_CAP);
        fresh[FLG_STALL_TO] = stall_expired;
        fresh[FLG_RSP_TO]   = wait_expired;
        fresh[FLG_EARLY]    = NEED_DELAY && respond && none_inflight && accept;
        fresh[FLG_ORPHAN]   = respond && none_inflight && !accept;
        fresh[FLG_DUAL]     = cyc && ack && err;
        fresh[FLG_IDLE]     = !ALLOW_HOLD_OPEN && cyc && !stb && none_inflight && !respond;
        fresh[FLG_GAP]      = !ALLOW_GAPS && cyc && st_q.cyc_prev && stb && !st_q.stb_prev;
        fresh[FLG_HOLD]     = hold_broke;

        st_d          = st_q;
        st_d.viol     = st_q.viol | fresh;
        st_d.cyc_prev = cyc;
        st_d.stb_prev = cyc && stb;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign viol     = st_q.viol;
    assign viol_any = |st_q.viol;

endmodule

// File: rtl/mon_checker.sv
module mon_checker
    import bus_mon_pkg::*;
#(
    parameter int CW = 4
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 cyc,
    input logic                 stb,
    input logic                 stall,
    input logic                 ack,
    input logic                 err,
    input logic [CW-1:0]        req_count,
    input logic [CW-1:0]        rsp_count,
    input logic [CW-1:0]        inflight,
    input logic [NUM_FLAGS-1:0] viol
);
    AST_REQ_STEP: assert property (@(posedge clk) disable iff (rst)
        (cyc && stb && !stall) |=> (req_count == CW'($past(req_count) + 1'b1))); // R1

    AST_RSP_STEP: assert property (@(posedge clk) disable iff (rst)
        (cyc && (ack || err)) |=> (rsp_count == CW'($past(rsp_count) + 1'b1))); // R2

    AST_IDLE_CLEAR: assert property (@(posedge clk) disable iff (rst)
        !cyc |=> (req_count == '0 && rsp_count == '0)); // R3

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        !cyc |-> (inflight == '0)); // R3

    AST_DUAL_FLAG: assert property (@(posedge clk) disable iff (rst)
        (cyc && ack && err) |=> viol[FLG_DUAL]); // R9

    AST_STICKY: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((viol & $past(viol)) == $past(viol))); // R13

endmodule

bind bus_link_monitor mon_checker #(.CW(DEPTH_BITS)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cyc       (cyc),
    .stb       (stb),
    .stall     (stall),
    .ack       (ack),
    .err       (err),
    .req_count (req_count),
    .rsp_count (rsp_count),
    .inflight  (inflight),
    .viol      (viol)
);

// File: tb/bus_link_monitor_test.sv
module bus_link_monitor_test;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 16;
    localparam int DW = 32;
    localparam int DB = 4;
    localparam int WATCHDOG = 20000;

    localparam int B_DEPTH = 1,   B_CAP = 2,    B_STALL = 4,  B_WAIT = 8;
    localparam int B_EARLY = 16,  B_ORPHAN = 32, B_DUAL = 64, B_IDLE = 128;
    localparam int B_GAP = 256,   B_HOLD = 512;

    logic clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic rst = 1'b1;
    logic cyc = 0, stb = 0, we = 0, ack = 0, stall = 0, err = 0;
    logic [AW-1:0]   adr = '0;
    logic [DW-1:0]   dat_w = '0;
    logic [DW/8-1:0] sel = '0;

    logic [DB-1:0] req_s, rsp_s, inf_s, req_p, rsp_p, inf_p;
    logic [9:0]    viol_s, viol_p;
    logic          any_s, any_p;

    int errors = 0, checks = 0;
    int req_m = 0, rsp_m = 0;
    bit done = 0;

    bus_link_monitor #(
        .AW(AW), .DW(DW), .DEPTH_BITS(DB), .MAX_REQ(6),
        .STALL_LIMIT(3), .RSP_LIMIT(4),
        .ALLOW_HOLD_OPEN(1'b0), .ALLOW_GAPS(1'b0), .NEED_DELAY(1'b1)
    ) uut (
        .clk(clk), .rst(rst), .cyc(cyc), .stb(stb), .we(we), .adr(adr),
        .dat_w(dat_w), .sel(sel), .ack(ack), .stall(stall), .err(err),
        .req_count(req_s), .rsp_count(rsp_s), .inflight(inf_s),
        .viol(viol_s), .viol_any(any_s)
    );

    bus_link_monitor #(
        .AW(AW), .DW(DW), .DEPTH_BITS(DB), .MAX_REQ(0),
        .STALL_LIMIT(0), .RSP_LIMIT(0),
        .ALLOW_HOLD_OPEN(1'b1), .ALLOW_GAPS(1'b1), .NEED_DELAY(1'b0)
    ) uut_alt (
        .clk(clk), .rst(rst), .cyc(cyc), .stb(stb), .we(we), .adr(adr),
        .dat_w(dat_w), .sel(sel), .ack(ack), .stall(stall), .err(err),
        .req_count(req_p), .rsp_count(rsp_p), .inflight(inf_p),
        .viol(viol_p), .viol_any(any_p)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int wrap(input int v);
        return v & ((1 << DB) - 1);
    endfunction

    task automatic step();
        logic acc, rsp;
        acc = cyc && stb && !stall;
        rsp = cyc && (ack || err);
        @(posedge clk);
        #1;
        if (rst || !cyc) begin
            req_m = 0;
            rsp_m = 0;
        end else begin
            if (acc) req_m = wrap(req_m + 1);
            if (rsp) rsp_m = wrap(rsp_m + 1);
        end
    endtask

    task automatic drive(input logic c, input logic s, input logic st,
                         input logic a, input logic e);
        cyc = c; stb = s; stall = st; ack = a; err = e;
    endtask

    task automatic do_reset();
        drive(0, 0, 0, 0, 0);
        we = 0; adr = '0; dat_w = '0; sel = '0;
        rst = 1;
        step();
        step();
        rst = 0;
    endtask

    task automatic run_txn(input int n);
        int issued, stall_run, wait_run, pend;
        logic [31:0] salt;
        logic acc, rsp;
        issued = 0; stall_run = 0; wait_run = 0; pend = 0;
        salt = $urandom;
        we  = salt[31];
        sel = salt[31] ? 4'hF : 4'h3;
        cyc = 1;
        while (issued < n || pend > 0) begin
            stb   = (issued < n);
            adr   = AW'(issued * 4 + int'(salt[7:0]));
            dat_w = salt ^ (32'(issued) * 32'h01010101);
            stall = stb && (stall_run < 2) && ($urandom % 3 == 0);
            ack = 0; err = 0;
            if (pend > 0 && (wait_run >= 2 || $urandom % 2 == 1)) begin
                if ($urandom % 8 == 0) err = 1;
                else                   ack = 1;
            end
            acc = stb && !stall;
            rsp = ack || err;
            step();
            check("R1 strict req_count", int'(req_s), req_m);
            check("R1 permissive req_count", int'(req_p), req_m);
            check("R2 strict rsp_count", int'(rsp_s), rsp_m);
            check("R3 strict inflight", int'(inf_s), wrap(req_m - rsp_m));
            stall_run = (stb && stall) ? stall_run + 1 : 0;
            wait_run  = (pend > 0 && !rsp) ? wait_run + 1 : 0;
            if (acc) issued++;
            pend = wrap(req_m - rsp_m);
        end
        drive(0, 0, 0, 0, 0);
        step();
        check("R3 counts clear after cycle", int'(req_s) + int'(rsp_s), 0);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog (all requirements): actual=expired expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED));
        do_reset();
        check("R3 reset req_count", int'(req_s), 0);
        check("R3 reset rsp_count", int'(rsp_s), 0);
        check("R13 reset flags", int'(viol_s), 0);
        check("R13 reset any", int'(any_s), 0);

        // R1 R2 R3: legal random traffic leaves every flag clear
        for (int t = 0; t < 40; t++) run_txn(1 + int'($urandom % 5));
        check("R13 strict clean after random", int'(viol_s), 0);
        check("R13 permissive clean after random", int'(viol_p), 0);

        // R6 stall timeout
        do_reset();
        adr = 16'h0040;
        drive(1, 1, 1, 0, 0);
        step(); step(); step();
        check("R6 three stalls legal", int'(viol_s), 0);
        step();
        check("R6 fourth stall flags", int'(viol_s), B_STALL);
        check("R6 limit zero silent", int'(viol_p), 0);
        check("R13 any follows flag", int'(any_s), 1);

        // R7 response timeout
        do_reset();
        drive(1, 1, 0, 0, 0);
        step();
        drive(1, 0, 0, 0, 0);
        step(); step(); step(); step();
        check("R7 four waits legal", int'(viol_s), 0);
        step();
        check("R7 fifth wait flags", int'(viol_s), B_WAIT);
        check("R7 limit zero silent", int'(viol_p), 0);

        // R9 orphan response
        do_reset();
        drive(1, 0, 0, 1, 0);
        step();
        check("R9 orphan strict", int'(viol_s), B_ORPHAN);
        check("R9 orphan permissive", int'(viol_p), B_ORPHAN);
        drive(0, 0, 0, 0, 0);
        step();
        check("R13 orphan flag sticky", int'(viol_s), B_ORPHAN);

        // R9 ack with err
        do_reset();
        drive(1, 1, 0, 0, 0);
        step();
        drive(1, 0, 0, 1, 1);
        step();
        check("R9 dual strict", int'(viol_s), B_DUAL);
        check("R9 dual permissive", int'(viol_p), B_DUAL);
        check("R2 dual counts once", int'(rsp_s), 1);

        // R8 same-clock answer
        do_reset();
        drive(1, 1, 0, 1, 0);
        step();
        check("R8 early strict", int'(viol_s), B_EARLY);
        check("R8 early permitted", int'(viol_p), 0);
        check("R1 R2 same-clock counts", int'(req_s) * 16 + int'(rsp_s), 17);

        // R10 hold-open
        do_reset();
        drive(1, 1, 0, 0, 0);
        step();
        drive(1, 0, 0, 1, 0);
        step();
        check("R10 last answer legal", int'(viol_s), 0);
        drive(1, 0, 0, 0, 0);
        step();
        check("R10 idle open strict", int'(viol_s), B_IDLE);
        check("R10 idle open permitted", int'(viol_p), 0);

        // R11 strobe gap
        do_reset();
        drive(1, 1, 0, 0, 0);
        step();
        drive(1, 0, 0, 0, 0);
        step();
        check("R11 strobe low legal", int'(viol_s), 0);
        drive(1, 1, 0, 0, 0);
        step();
        check("R11 gap strict", int'(viol_s), B_GAP);
        check("R11 gap permitted", int'(viol_p), 0);

        // R12 field changes during stall
        do_reset();
        adr = 16'h0001;
        drive(1, 1, 1, 0, 0);
        step();
        adr = 16'h0002;
        step();
        check("R12 address moved strict", int'(viol_s), B_HOLD);
        check("R12 address moved permissive", int'(viol_p), B_HOLD);

        // R12 strobe dropped during stall
        do_reset();
        drive(1, 1, 1, 0, 0);
        step();
        drive(1, 0, 0, 0, 0);
        step();
        check("R12 strobe drop permissive", int'(viol_p), B_HOLD);
        check("R12 R10 strobe drop strict", int'(viol_s), B_HOLD + B_IDLE);

        // R5 request cap
        do_reset();
        drive(1, 1, 0, 0, 0);
        step();
        drive(1, 1, 0, 1, 0);
        for (int k = 0; k < 5; k++) step();
        check("R5 six requests legal", int'(viol_s), 0);
        step();
        check("R5 seventh request flags", int'(viol_s), B_CAP);
        check("R5 no cap permissive", int'(viol_p), 0);
        check("R1 seven accepted", int'(req_s), 7);

        // R4 depth on the permissive instance
        do_reset();
        drive(1, 1, 0, 0, 0);
        for (int k = 0; k < 15; k++) begin
            adr = AW'(k);
            step();
        end
        check("R4 fifteen in flight", int'(inf_p), 15);
        check("R4 not yet flagged", int'(viol_p), 0);
        drive(1, 0, 0, 0, 0);
        step();
        check("R4 depth flag", int'(viol_p), B_DEPTH);

        // R3 gating and clearing
        cyc = 0;
        #1;
        check("R3 inflight gated", int'(inf_p), 0);
        check("R3 count before edge", int'(req_p), 15);
        step();
        check("R3 count cleared", int'(req_p), 0);
        step();
        check("R13 depth still set", int'(viol_p), B_DEPTH);
        check("R13 any permissive", int'(any_p), 1);
        do_reset();
        check("R13 reset clears", int'(viol_p), 0);
        check("R13 reset clears any", int'(any_p), 0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule